// File: doc/BRIEF.md
# FPGA Configuration Status Sequencer

This block models the device side of an FPGA configuration handshake. An external host drives an active-low request line. The block answers on an active-low status line, a done flag and an init-done flag. It also latches the configuration mode pins once, in the first cycle after reset. Reset is synchronous and active high, and it stands in for power-on reset.

A request that rises makes the block configure. A request that falls makes it clean the device, and it confirms the clean by pulling status low. Bitstream completion, fabric initialisation and the error and security events arrive as single-cycle abstract inputs.

Errors come in two kinds. A recoverable error gives a status-low pulse of fixed width, after which the host can pull the request low and try again. A fatal error, a tamper event or a double-bit ECC error locks the status line low until the next reset.

Top module: `cfg_status_seq`

## Requirements
- R1: `mode_held` is cleared by reset. It captures `mode_pins` in the first cycle after reset is released and keeps that value, whatever the pins do, until the next reset.
- R2: While reset is high, `stat_n`, `cfg_done` and `init_done` are 0. In the first cycle after reset is released, the block goes to idle with `stat_n`=0 if `cfg_req_n` is 0, or starts configuring with `stat_n`=1 if `cfg_req_n` is 1.
- R3: In idle, `cfg_req_n`=1 sets `stat_n` to 1 one cycle later, and configuration begins.
- R4: While configuring, `bits_done`=1 sets `cfg_done` one cycle later. After that, `fabric_ready`=1 sets `init_done` one cycle later. `fabric_ready` has no effect before `cfg_done` is set, so `init_done` is never 1 while `cfg_done` is 0.
- R5: `cfg_req_n`=0 while configuring or configured clears `cfg_done` and `init_done` one cycle later and starts cleaning. `stat_n` stays 1 for exactly CLEAN_CYC cycles and then goes to 0, and the block returns to idle.
- R6: `err_soft`=1 while configuring drives `stat_n` to 0 for exactly ERR_CYC cycles, with `cfg_done` and `init_done` held at 0. After the pulse, `stat_n` returns to 1 if `cfg_req_n` is 1. `err_soft` has no effect in any other state.
- R7: After an error pulse, `cfg_req_n`=0 takes the block to idle with `stat_n`=0 one cycle later. A later `cfg_req_n`=1 starts a new configuration.
- R8: Any of `err_fatal`, `tamper_evt` or `ecc_dbl` forces `stat_n`, `cfg_done` and `init_done` to 0 one cycle later, in any state. They stay 0 whatever the inputs do, until reset.
- R9: When several events fall in the same cycle while configuring, the block takes the first of this list: fatal event, request low, `err_soft`, `bits_done`.
- R10: `stat_n` rises only in a cycle that follows a cycle with `cfg_req_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, standing in for power-on reset |
| cfg_req_n | input | 1 | Active-low configuration request from the host |
| mode_pins | input | MODE_W | Configuration mode select pins |
| bits_done | input | 1 | Strobe: complete bitstream received |
| fabric_ready | input | 1 | Strobe: fabric initialisation finished |
| err_soft | input | 1 | Strobe: recoverable configuration error |
| err_fatal | input | 1 | Strobe: unrecoverable configuration error |
| tamper_evt | input | 1 | Strobe: security or tamper event |
| ecc_dbl | input | 1 | Strobe: double-bit ECC error in internal memory |
| stat_n | output | 1 | Active-low configuration status |
| cfg_done | output | 1 | Bitstream accepted |
| init_done | output | 1 | Device in user mode |
| mode_held | output | MODE_W | Mode pins as latched after reset |

## Verification
The main collision is a recoverable error that arrives in the same cycle as the bitstream-complete strobe. A second collision is a fatal event that arrives together with completion. The bench provokes both by directed stimulus. It then expects the error path to win: the status pulse starts and `cfg_done` stays 0, or the block locks. A fixed-seed random phase then produces further coincidences of strobes and request edges. The host obeys the rule that the request changes only when it matches the status line. Each output is compared every cycle against a reference model built from the priority order.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    SQ_BOOT,
    SQ_IDLE,
    SQ_CONFIG,
    SQ_USER,
    SQ_CLEAN,
    SQ_ERR_PULSE,
    SQ_ERR_HOLD,
    SQ_LOCKED
  } seq_state_t;

  function automatic logic fatal_hit(input logic f, input logic t, input logic e);
    return f | t | e;
  endfunction
endpackage

// File: rtl/cfg_cycle_timer.sv
// Fixed-length interval timer: after start, expire is high in the LEN-th cycle.
module cfg_cycle_timer #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expire
);
  localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;

  generate
    if (LEN == 1) begin : g_single
      logic armed;
      always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= start;
      end
      assign expire = armed;
    end else begin : g_count
      logic [CNT_W-1:0] cnt;
      logic             busy;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt  <= '0;
          busy <= 1'b0;
        end else if (start) begin
          cnt  <= CNT_W'(LEN - 1);
          busy <= 1'b1;
        end else if (busy) begin
          if (cnt == '0) busy <= 1'b0;
          else           cnt  <= cnt - 1'b1;
        end
      end
      assign expire = busy && (cnt == '0);
    end
  endgenerate
endmodule

// File: rtl/cfg_mode_latch.sv
// Captures the mode pins once, in the boot cycle.
module cfg_mode_latch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample,
  input  logic [W-1:0] pins,
  output logic [W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst)         held <= '0;
    else if (sample) held <= pins;
  end
endmodule

// File: rtl/cfg_status_seq.sv
module cfg_status_seq
  import cfg_seq_pkg::*;
#(
  parameter int MODE_W    = 3,
  parameter int CLEAN_CYC = 16,
  parameter int ERR_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_req_n,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              bits_done,
  input  logic              fabric_ready,
  input  logic              err_soft,
  input  logic              err_fatal,
  input  logic              tamper_evt,
  input  logic              ecc_dbl,
  output logic              stat_n,
  output logic              cfg_done,
  output logic              init_done,
  output logic [MODE_W-1:0] mode_held
);
  seq_state_t st_q, st_nx;
  logic stat_nx, done_nx, init_nx;
  logic clean_go, err_go, clean_exp, err_exp;
  logic fatal_any;

  assign fatal_any = fatal_hit(err_fatal, tamper_evt, ecc_dbl);

  cfg_mode_latch #(.W(MODE_W)) u_mode (
    .clk    (clk),
    .rst    (rst),
    .sample (st_q == SQ_BOOT),
    .pins   (mode_pins),
    .held   (mode_held)
  );

  cfg_cycle_timer #(.LEN(CLEAN_CYC)) u_clean_tmr (
    .clk    (clk),
    .rst    (rst),
    .start  (clean_go),
    .expire (clean_exp)
  );

  cfg_cycle_timer #(.LEN(ERR_CYC)) u_err_tmr (
    .clk    (clk),
    .rst    (rst),
    .start  (err_go),
    .expire (err_exp)
  );

  always_comb begin
    st_nx    = st_q;
    stat_nx  = stat_n;
    done_nx  = cfg_done;
    init_nx  = init_done;
    clean_go = 1'b0;
    err_go   = 1'b0;
    if (fatal_any) begin
      st_nx   = SQ_LOCKED;
      stat_nx = 1'b0;
      done_nx = 1'b0;
      init_nx = 1'b0;
    end else begin
      unique case (st_q)
        SQ_BOOT: begin
          if (cfg_req_n) begin
            st_nx   = SQ_CONFIG;
            stat_nx = 1'b1;
          end else begin
            st_nx   = SQ_IDLE;
          end
        end
        SQ_IDLE: begin
          if (cfg_req_n) begin
            st_nx   = SQ_CONFIG;
            stat_nx = 1'b1;
          end
        end
        SQ_CONFIG: begin
          if (!cfg_req_n) begin
            st_nx    = SQ_CLEAN;
            clean_go = 1'b1;
          end else if (err_soft) begin
            st_nx   = SQ_ERR_PULSE;
            stat_nx = 1'b0;
            err_go  = 1'b1;
          end else if (bits_done) begin
            st_nx   = SQ_USER;
            done_nx = 1'b1;
          end
        end
        SQ_USER: begin
          if (!cfg_req_n) begin
            st_nx    = SQ_CLEAN;
            clean_go = 1'b1;
            done_nx  = 1'b0;
            init_nx  = 1'b0;
          end else if (fabric_ready) begin
            init_nx = 1'b1;
          end
        end
        SQ_CLEAN: begin
          if (clean_exp) begin
            st_nx   = SQ_IDLE;
            stat_nx = 1'b0;
          end
        end
        SQ_ERR_PULSE: begin
          if (err_exp) begin
            if (cfg_req_n) begin
              st_nx   = SQ_ERR_HOLD;
              stat_nx = 1'b1;
            end else begin
              st_nx   = SQ_IDLE;
            end
          end
        end
        SQ_ERR_HOLD: begin
          if (!cfg_req_n) begin
            st_nx   = SQ_IDLE;
            stat_nx = 1'b0;
          end
        end
        SQ_LOCKED: begin
          stat_nx = 1'b0;
          done_nx = 1'b0;
          init_nx = 1'b0;
        end
        default: st_nx = SQ_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SQ_BOOT;
      stat_n    <= 1'b0;
      cfg_done  <= 1'b0;
      init_done <= 1'b0;
    end else begin
      st_q      <= st_nx;
      stat_n    <= stat_nx;
      cfg_done  <= done_nx;
      init_done <= init_nx;
    end
  end
endmodule

// File: rtl/cfg_status_seq_chk.sv
module cfg_status_seq_chk #(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_req_n,
  input logic              bits_done,
  input logic              err_fatal,
  input logic              tamper_evt,
  input logic              ecc_dbl,
  input logic              stat_n,
  input logic              cfg_done,
  input logic              init_done,
  input logic [MODE_W-1:0] mode_held
);
  logic fatal_seen, booted;

  always_ff @(posedge clk) begin
    if (rst) begin
      fatal_seen <= 1'b0;
      booted     <= 1'b0;
    end else begin
      booted <= 1'b1;
      if (err_fatal || tamper_evt || ecc_dbl) fatal_seen <= 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!stat_n && !cfg_done && !init_done)); // R2

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    booted |=> $stable(mode_held)); // R1

  AST_INIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    init_done |-> cfg_done); // R4

  AST_DONE_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_done) |-> $past(bits_done)); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    fatal_seen |-> (!stat_n && !cfg_done && !init_done)); // R8

  AST_RISE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_n) |-> $past(cfg_req_n)); // R10
endmodule

bind cfg_status_seq cfg_status_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_req_n  (cfg_req_n),
  .bits_done  (bits_done),
  .err_fatal  (err_fatal),
  .tamper_evt (tamper_evt),
  .ecc_dbl    (ecc_dbl),
  .stat_n     (stat_n),
  .cfg_done   (cfg_done),
  .init_done  (init_done),
  .mode_held  (mode_held)
);

// File: tb/cfg_status_seq_bench.sv
module cfg_status_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MW    = 3;
  localparam int CLEAN = 5;
  localparam int ERR   = 4;
  localparam int LIMIT = 150000;

  localparam int M_BOOT = 0, M_IDLE = 1, M_CFG = 2, M_USR = 3,
                 M_CLN = 4, M_EP = 5, M_EH = 6, M_LOCK = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_n = 1'b0;
  logic [MW-1:0] mode_pins = '0;
  logic bits_done = 1'b0, fabric_ready = 1'b0, err_soft = 1'b0;
  logic err_fatal = 1'b0, tamper_evt = 1'b0, ecc_dbl = 1'b0;
  logic stat_n, cfg_done, init_done;
  logic [MW-1:0] mode_held;

  int nchk = 0;
  int nerr = 0;
  int cyc_cnt = 0;

  // reference model state
  int ms = M_BOOT;
  int mcnt = 0;
  logic mstat = 1'b0, mdone = 1'b0, minit = 1'b0;
  logic [MW-1:0] mmode = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_status_seq #(.MODE_W(MW), .CLEAN_CYC(CLEAN), .ERR_CYC(ERR)) u_cfg_status_seq (
    .clk          (clk),
    .rst          (rst),
    .cfg_req_n    (req_n),
    .mode_pins    (mode_pins),
    .bits_done    (bits_done),
    .fabric_ready (fabric_ready),
    .err_soft     (err_soft),
    .err_fatal    (err_fatal),
    .tamper_evt   (tamper_evt),
    .ecc_dbl      (ecc_dbl),
    .stat_n       (stat_n),
    .cfg_done     (cfg_done),
    .init_done    (init_done),
    .mode_held    (mode_held)
  );

  // Reference model built from the requirements
  always @(posedge clk) begin
    cyc_cnt++;
    if (rst) begin
      ms = M_BOOT; mstat = 0; mdone = 0; minit = 0; mmode = '0; mcnt = 0;
    end else begin
      if (ms == M_BOOT) mmode = mode_pins;
      if (err_fatal || tamper_evt || ecc_dbl) begin
        ms = M_LOCK; mstat = 0; mdone = 0; minit = 0;
      end else begin
        case (ms)
          M_BOOT: if (req_n) begin ms = M_CFG; mstat = 1; end else ms = M_IDLE;
          M_IDLE: if (req_n) begin ms = M_CFG; mstat = 1; end
          M_CFG: begin
            if (!req_n) begin ms = M_CLN; mcnt = 1; end
            else if (err_soft) begin ms = M_EP; mstat = 0; mcnt = 1; end
            else if (bits_done) begin ms = M_USR; mdone = 1; end
          end
          M_USR: begin
            if (!req_n) begin ms = M_CLN; mcnt = 1; mdone = 0; minit = 0; end
            else if (fabric_ready) minit = 1;
          end
          M_CLN: if (mcnt == CLEAN) begin ms = M_IDLE; mstat = 0; end else mcnt++;
          M_EP: begin
            if (mcnt == ERR) begin
              if (req_n) begin ms = M_EH; mstat = 1; end else ms = M_IDLE;
            end else mcnt++;
          end
          M_EH: if (!req_n) begin ms = M_IDLE; mstat = 0; end
          default: ;
        endcase
      end
    end
  end

  function automatic void chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endfunction

  task automatic fin();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc_cnt > LIMIT) begin
      nerr++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc_cnt, LIMIT);
      fin();
    end
  end

  // one cycle: inputs already driven; compare at the next falling edge
  task automatic cyc(string tag);
    @(negedge clk);
    chk(tag, "stat_n", int'(stat_n), int'(mstat));
    chk(tag, "cfg_done", int'(cfg_done), int'(mdone));
    chk(tag, "init_done", int'(init_done), int'(minit));
    chk(tag, "mode_held", int'(mode_held), int'(mmode));
  endtask

  task automatic clr();
    bits_done = 0; fabric_ready = 0; err_soft = 0;
    err_fatal = 0; tamper_evt = 0; ecc_dbl = 0;
  endtask

  task automatic do_reset(logic req_at_boot, logic [MW-1:0] m);
    rst = 1; req_n = req_at_boot; mode_pins = m; clr();
    cyc("R2"); cyc("R2");
    chk("R2", "stat_n in reset", int'(stat_n), 0);
    rst = 0;
    cyc("R2");
  endtask

  initial begin
    int w;
    int r;
    r = $urandom(32'h5eed_0042);
    @(negedge clk);

    // boot with request low
    do_reset(1'b0, 3'd5);
    chk("R1", "mode after boot", int'(mode_held), 5);
    chk("R2", "idle status", int'(stat_n), 0);
    mode_pins = 3'd2;
    for (int i = 0; i < 3; i++) cyc("R1");
    chk("R1", "mode ignores pins", int'(mode_held), 5);
    err_soft = 1; cyc("R6"); clr();
    chk("R6", "err_soft in idle", int'(stat_n), 0);

    // request rises
    req_n = 1; cyc("R3");
    chk("R3", "stat_n after rise", int'(stat_n), 1);
    fabric_ready = 1; cyc("R4"); clr();
    chk("R4", "init before done", int'(init_done), 0);
    bits_done = 1; cyc("R4"); clr();
    chk("R4", "done", int'(cfg_done), 1);
    cyc("R4"); cyc("R4");
    fabric_ready = 1; cyc("R4"); clr();
    chk("R4", "init", int'(init_done), 1);

    // cleaning
    req_n = 0; cyc("R5");
    chk("R5", "done cleared", int'(cfg_done), 0);
    chk("R5", "init cleared", int'(init_done), 0);
    w = 0;
    while (stat_n && w < 50) begin w++; cyc("R5"); end
    chk("R5", "clean width", w, CLEAN);

    // reconfigure; error coinciding with completion
    req_n = 1; cyc("R5");
    chk("R5", "reconfigure", int'(stat_n), 1);
    err_soft = 1; bits_done = 1; cyc("R9"); clr();
    chk("R9", "error beats done", int'(cfg_done), 0);
    w = 0;
    while (!stat_n && w < 50) begin w++; cyc("R6"); end
    chk("R6", "error pulse width", w, ERR);
    chk("R6", "done after pulse", int'(cfg_done), 0);
    req_n = 0; cyc("R7");
    chk("R7", "idle after error", int'(stat_n), 0);
    req_n = 1; cyc("R7");
    chk("R7", "restart after error", int'(stat_n), 1);

    // request low beats err_soft
    req_n = 0; err_soft = 1; cyc("R9"); clr();
    for (int i = 0; i < CLEAN; i++) cyc("R9");
    chk("R9", "clean took priority", int'(stat_n), 0);

    // fatal with completion
    req_n = 1; cyc("R3");
    err_fatal = 1; bits_done = 1; cyc("R8"); clr();
    chk("R8", "locked", int'(stat_n), 0);
    chk("R9", "fatal beats done", int'(cfg_done), 0);
    req_n = 0; cyc("R8"); req_n = 1; cyc("R8"); cyc("R8");
    chk("R8", "stays locked", int'(stat_n), 0);

    // boot with request high; tamper in user mode
    do_reset(1'b1, 3'd6);
    chk("R2", "boot to config", int'(stat_n), 1);
    chk("R1", "mode resampled", int'(mode_held), 6);
    bits_done = 1; cyc("R4"); clr();
    tamper_evt = 1; cyc("R8"); clr();
    chk("R8", "tamper lock", int'(cfg_done), 0);

    // ecc in idle
    do_reset(1'b0, 3'd1);
    ecc_dbl = 1; cyc("R8"); clr();
    req_n = 1; cyc("R8"); cyc("R8");
    chk("R8", "ecc lock", int'(stat_n), 0);

    // random phase
    do_reset(1'b0, 3'd3);
    for (int n = 0; n < 4000; n++) begin
      if (ms == M_LOCK && ($urandom % 16) == 0) do_reset(1'($urandom % 2), 3'($urandom));
      if (req_n == stat_n && ($urandom % 6) == 0) req_n = ~req_n;
      bits_done    = (($urandom % 6) == 0);
      fabric_ready = (($urandom % 6) == 0);
      err_soft     = (($urandom % 24) == 0);
      err_fatal    = (($urandom % 700) == 0);
      tamper_evt   = (($urandom % 900) == 0);
      ecc_dbl      = (($urandom % 900) == 0);
      mode_pins    = 3'($urandom);
      cyc("R10");
    end
    clr();
    fin();
  end
endmodule